// File: doc/BRIEF.md
# Cluster Fetch Sequencer with Lock-Step Branching

This block sequences instruction fetch for one cluster of a clustered wide-issue machine in which every cluster owns a private program counter. The cluster's code is laid out in consecutive local words, so fall-through fetch advances the local PC by a fixed step. Control transfer is split into three operations. A prepare operation loads a cluster-specific address into a local target register. A broadcast operation puts a compare result on the predicate network. A branch operation, replicated in every cluster, reads the local target register and the shared predicate. All clusters therefore redirect in the same cycle to the same logical block, and each uses its own local address.

The block drives the local instruction-memory address and request strobe. It takes the fetched operation's class and fields, the global stall line, and the incoming predicate network. It raises a stall request while a branch is waiting for its predicate. A compiler-placed sleep operation switches the cluster off at a block boundary. A wake indication, given in the cycle the awake clusters branch, restarts fetch at a selected local target register.

Top module: `fetch_seq_cluster`

## Requirements
- R1: After reset the address output equals the ENTRY parameter, the request strobe is high (awake), no stall request and no broadcast are driven, and all target registers hold zero.
- R2: An awake cluster that accepts a valid operation of class 0 (plain), 1 (prepare) or 2 (broadcast) advances its address by STEP on the next edge. With no valid operation the address holds.
- R3: A prepare operation (class 1) writes `op_data_i` into the target register selected by `op_reg_i`. A later branch that names a register never written uses that register's current contents (zero after reset) and raises no error.
- R4: A broadcast operation (class 2) drives `pred_bcast_o` high with `pred_bcast_val_o` equal to `op_pred_i` in the same cycle, but only while `stall_i` is low.
- R5: A branch (class 3) with predicate 1 loads the named target register into the PC. With predicate 0 it falls through by STEP. Either way the predicate is consumed.
- R6: A branch or sleep operation with no predicate held and none arriving drives `stall_req_o` high and the PC holds. A predicate arriving on the network is usable in the cycle it arrives.
- R7: While `stall_i` is high, the PC, target registers and sleep state do not change, no broadcast is issued and no wake takes effect. A predicate arriving during the stall is kept.
- R8: A sleep operation (class 4) waits for the predicate like a branch, consumes it, and puts the cluster to sleep with the PC unchanged. While asleep the request strobe is low, no stall request or broadcast is driven, and fetched operations have no effect.
- R9: While asleep, `wake_i` with `stall_i` low loads the target register named by `wake_reg_i` into the PC and sets the cluster awake on the next edge. `wake_i` has no effect on an awake cluster.
- R10: While asleep the block still latches predicates from the network. The wake cycle consumes the held predicate, so a branch right after waking waits for a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Fetched operation present for the current address |
| op_kind_i | input | 3 | Operation class: 0 plain, 1 prepare, 2 broadcast, 3 branch, 4 sleep |
| op_reg_i | input | 2 | Target register index for prepare and branch |
| op_data_i | input | 32 | Address written by a prepare operation |
| op_pred_i | input | 1 | Compare result sent by a broadcast operation |
| pred_net_valid_i | input | 1 | Predicate arriving from the network this cycle |
| pred_net_value_i | input | 1 | Value of the arriving predicate |
| stall_i | input | 1 | Global lock-step stall |
| wake_i | input | 1 | Wake indication for a sleeping cluster |
| wake_reg_i | input | 2 | Target register giving the resume address on wake |
| imem_addr_o | output | 32 | Local program counter to instruction memory |
| imem_req_o | output | 1 | Fetch request strobe, low while asleep |
| stall_req_o | output | 1 | Stall request while a branch waits for its predicate |
| pred_bcast_o | output | 1 | Predicate broadcast strobe |
| pred_bcast_val_o | output | 1 | Broadcast predicate value |

## Verification
Fetch is exercised with straight-line runs, gaps with no valid operation, taken and not-taken branches, and branches whose predicate comes early, arrives the same cycle, comes after several waiting cycles, or arrives under a global stall. These cases separate the bypass path from the held predicate and show that the predicate is consumed exactly once. A sleep/wake sequence feeds operations to the sleeping cluster, delivers a predicate to it, and holds a wake under stall. This tells ignored stimulus apart from lost state and shows that waking discards the held predicate. A branch on an unwritten register and a wake pulse to an awake cluster cover the remaining corners.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
   typedef enum logic [2:0] {
      OPK_PLAIN  = 3'd0,
      OPK_PREP   = 3'd1,
      OPK_BCAST  = 3'd2,
      OPK_BRANCH = 3'd3,
      OPK_SLEEP  = 3'd4
   } opkind_e;

   function automatic opkind_e decode_kind(input logic [2:0] raw);
      case (raw)
         3'd1:    return OPK_PREP;
         3'd2:    return OPK_BCAST;
         3'd3:    return OPK_BRANCH;
         3'd4:    return OPK_SLEEP;
         default: return OPK_PLAIN;
      endcase
   endfunction
endpackage

// File: rtl/fseq_target_regs.sv
module fseq_target_regs #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b
);
   logic [DATA_W-1:0] bank_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            bank_q[g] <= wr_data;
      end
   end

   assign rd_data_a = bank_q[rd_idx_a];
   assign rd_data_b = bank_q[rd_idx_b];
endmodule

// File: rtl/fseq_pred_track.sv
module fseq_pred_track #(
   parameter bit BYPASS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic net_valid,
   input  logic net_value,
   input  logic consume,
   output logic ready,
   output logic value
);
   logic held_v_q;
   logic held_val_q;
   logic keep_arrival;

   if (BYPASS) begin : g_bypass
      assign ready        = held_v_q | net_valid;
      assign value        = net_valid ? net_value : held_val_q;
      assign keep_arrival = 1'b0;
   end else begin : g_registered
      assign ready        = held_v_q;
      assign value        = held_val_q;
      assign keep_arrival = net_valid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_v_q   <= 1'b0;
         held_val_q <= 1'b0;
      end else if (consume) begin
         held_v_q   <= keep_arrival;
         held_val_q <= keep_arrival ? net_value : held_val_q;
      end else if (net_valid) begin
         held_v_q   <= 1'b1;
         held_val_q <= net_value;
      end
   end
endmodule

// File: rtl/fseq_pc_ctrl.sv
module fseq_pc_ctrl #(
   parameter int          PC_W  = 32,
   parameter int          STEP  = 1,
   parameter logic [31:0] ENTRY = 32'h0000_0100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            do_seq,
   input  logic            do_branch,
   input  logic            br_taken,
   input  logic [PC_W-1:0] br_target,
   input  logic            do_sleep,
   input  logic            do_wake,
   input  logic [PC_W-1:0] wake_target,
   output logic [PC_W-1:0] pc,
   output logic            asleep
);
   localparam logic [PC_W-1:0] STEP_V  = PC_W'(STEP);
   localparam logic [PC_W-1:0] ENTRY_V = PC_W'(ENTRY);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_d;
   logic            asleep_q;
   logic            asleep_d;
   logic [PC_W-1:0] fall_through;

   assign fall_through = pc_q + STEP_V;

   always_comb begin
      pc_d     = pc_q;
      asleep_d = asleep_q;
      if (do_wake) begin
         pc_d     = wake_target;
         asleep_d = 1'b0;
      end else if (do_sleep) begin
         asleep_d = 1'b1;
      end else if (do_branch) begin
         pc_d = br_taken ? br_target : fall_through;
      end else if (do_seq) begin
         pc_d = fall_through;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= ENTRY_V;
         asleep_q <= 1'b0;
      end else begin
         pc_q     <= pc_d;
         asleep_q <= asleep_d;
      end
   end

   assign pc     = pc_q;
   assign asleep = asleep_q;
endmodule

// File: rtl/fetch_seq_cluster.sv
module fetch_seq_cluster #(
   parameter int          PC_W        = 32,
   parameter int          NUM_BTR     = 4,
   parameter int          INSTR_STEP  = 1,
   parameter logic [31:0] ENTRY       = 32'h0000_0100,
   parameter bit          PRED_BYPASS = 1'b1,
   localparam int         IDX_W       = $clog2(NUM_BTR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid_i,
   input  logic [2:0]       op_kind_i,
   input  logic [IDX_W-1:0] op_reg_i,
   input  logic [PC_W-1:0]  op_data_i,
   input  logic             op_pred_i,
   input  logic             pred_net_valid_i,
   input  logic             pred_net_value_i,
   input  logic             stall_i,
   input  logic             wake_i,
   input  logic [IDX_W-1:0] wake_reg_i,
   output logic [PC_W-1:0]  imem_addr_o,
   output logic             imem_req_o,
   output logic             stall_req_o,
   output logic             pred_bcast_o,
   output logic             pred_bcast_val_o
);
   import fseq_pkg::*;

   if (NUM_BTR < 2 || (NUM_BTR & (NUM_BTR - 1)) != 0) begin : g_chk_btr
      $error("NUM_BTR must be a power of two, at least 2");
   end
   if (PC_W < 8 || PC_W > 32) begin : g_chk_pcw
      $error("PC_W must lie in 8..32");
   end
   if (INSTR_STEP < 1) begin : g_chk_step
      $error("INSTR_STEP must be positive");
   end

   opkind_e         kind;
   logic            asleep;
   logic            awake;
   logic            op_live;
   logic            is_xfer;
   logic            pred_ready;
   logic            pred_value;
   logic            hold;
   logic            exec;
   logic            do_wake;
   logic            consume;
   logic [PC_W-1:0] op_target;
   logic [PC_W-1:0] wake_target;
   logic [PC_W-1:0] pc;

   assign kind    = decode_kind(op_kind_i);
   assign awake   = !asleep;
   assign op_live = awake && op_valid_i;
   assign is_xfer = (kind == OPK_BRANCH) || (kind == OPK_SLEEP);

   assign stall_req_o = op_live && is_xfer && !pred_ready;
   assign hold        = stall_i || stall_req_o;
   assign exec        = op_live && !hold;
   assign do_wake     = asleep && wake_i && !stall_i;
   assign consume     = (exec && is_xfer) || do_wake;

   assign pred_bcast_o     = op_live && (kind == OPK_BCAST) && !stall_i;
   assign pred_bcast_val_o = pred_bcast_o && op_pred_i;

   fseq_target_regs #(
      .NUM_REGS (NUM_BTR),
      .DATA_W   (PC_W)
   ) btr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (exec && (kind == OPK_PREP)),
      .wr_idx    (op_reg_i),
      .wr_data   (op_data_i),
      .rd_idx_a  (op_reg_i),
      .rd_idx_b  (wake_reg_i),
      .rd_data_a (op_target),
      .rd_data_b (wake_target)
   );

   fseq_pred_track #(
      .BYPASS (PRED_BYPASS)
   ) pred_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .net_valid (pred_net_valid_i),
      .net_value (pred_net_value_i),
      .consume   (consume),
      .ready     (pred_ready),
      .value     (pred_value)
   );

   fseq_pc_ctrl #(
      .PC_W  (PC_W),
      .STEP  (INSTR_STEP),
      .ENTRY (ENTRY)
   ) pc_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .do_seq      (exec && !is_xfer),
      .do_branch   (exec && (kind == OPK_BRANCH)),
      .br_taken    (pred_value),
      .br_target   (op_target),
      .do_sleep    (exec && (kind == OPK_SLEEP)),
      .do_wake     (do_wake),
      .wake_target (wake_target),
      .pc          (pc),
      .asleep      (asleep)
   );

   assign imem_addr_o = pc;
   assign imem_req_o  = awake;
endmodule

// File: rtl/fetch_seq_cluster_chk.sv
module fetch_seq_cluster_chk #(
   parameter int PC_W  = 32,
   parameter int STEP  = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid_i,
   input logic [2:0]      op_kind_i,
   input logic            stall_i,
   input logic            wake_i,
   input logic [PC_W-1:0] imem_addr_o,
   input logic            imem_req_o,
   input logic            stall_req_o,
   input logic            pred_bcast_o
);
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req_o && op_valid_i && op_kind_i == 3'd0 && !stall_i
      |=> imem_addr_o == $past(imem_addr_o) + PC_W'(STEP));

   assert_bcast_quiet_in_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pred_bcast_o |-> !stall_i);

   assert_wait_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req_o |=> imem_addr_o == $past(imem_addr_o));

   assert_stall_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> imem_addr_o == $past(imem_addr_o) && imem_req_o == $past(imem_req_o));

   assert_sleep_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !imem_req_o |-> !stall_req_o && !pred_bcast_o);

   assert_sleep_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !imem_req_o && !wake_i |=> imem_addr_o == $past(imem_addr_o) && !imem_req_o);

   assert_wake_resumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !imem_req_o && wake_i && !stall_i |=> imem_req_o);
endmodule

bind fetch_seq_cluster fetch_seq_cluster_chk #(
   .PC_W (PC_W),
   .STEP (INSTR_STEP)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid_i   (op_valid_i),
   .op_kind_i    (op_kind_i),
   .stall_i      (stall_i),
   .wake_i       (wake_i),
   .imem_addr_o  (imem_addr_o),
   .imem_req_o   (imem_req_o),
   .stall_req_o  (stall_req_o),
   .pred_bcast_o (pred_bcast_o)
);

// File: tb/fetch_seq_cluster_tb_top.sv
module fetch_seq_cluster_tb_top;
   localparam logic [31:0] ENTRY = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid_i;
   logic [2:0]  op_kind_i;
   logic [1:0]  op_reg_i;
   logic [31:0] op_data_i;
   logic        op_pred_i;
   logic        pred_net_valid_i;
   logic        pred_net_value_i;
   logic        stall_i;
   logic        wake_i;
   logic [1:0]  wake_reg_i;
   logic [31:0] imem_addr_o;
   logic        imem_req_o;
   logic        stall_req_o;
   logic        pred_bcast_o;
   logic        pred_bcast_val_o;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state
   logic [31:0] m_pc;
   logic [31:0] m_btr [4];
   bit          m_awake;
   bit          m_pv;
   bit          m_pval;

   always #10 clk = ~clk;

   fetch_seq_cluster #(.ENTRY(ENTRY)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .op_valid_i(op_valid_i), .op_kind_i(op_kind_i), .op_reg_i(op_reg_i),
      .op_data_i(op_data_i), .op_pred_i(op_pred_i),
      .pred_net_valid_i(pred_net_valid_i), .pred_net_value_i(pred_net_value_i),
      .stall_i(stall_i), .wake_i(wake_i), .wake_reg_i(wake_reg_i),
      .imem_addr_o(imem_addr_o), .imem_req_o(imem_req_o), .stall_req_o(stall_req_o),
      .pred_bcast_o(pred_bcast_o), .pred_bcast_val_o(pred_bcast_val_o)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare, then advance the model at the rising edge
   task automatic step(input string tag, input bit v, input int kind, input int rg,
                       input logic [31:0] data, input bit pr, input bit nv, input bit nval,
                       input bit st, input bit wk, input int wrg);
      bit br_like, pok, puse, sreq, bc, hold, used;
      @(negedge clk);
      op_valid_i = v; op_kind_i = 3'(kind); op_reg_i = 2'(rg); op_data_i = data;
      op_pred_i = pr; pred_net_valid_i = nv; pred_net_value_i = nval;
      stall_i = st; wake_i = wk; wake_reg_i = 2'(wrg);
      #2;
      br_like = m_awake && v && (kind == 3 || kind == 4);
      pok     = m_pv || nv;
      puse    = nv ? nval : m_pval;
      sreq    = br_like && !pok;
      bc      = m_awake && v && kind == 2 && !st;
      hold    = st || sreq;
      check(tag, "addr", imem_addr_o, m_pc);
      check(tag, "req", 32'(imem_req_o), 32'(m_awake));
      check(tag, "stall_req", 32'(stall_req_o), 32'(sreq));
      check(tag, "bcast", 32'(pred_bcast_o), 32'(bc));
      if (bc) check(tag, "bcast_val", 32'(pred_bcast_val_o), 32'(pr));
      @(posedge clk);
      used = 1'b0;
      if (m_awake) begin
         if (v && !hold) begin
            case (kind)
               1: begin m_btr[rg] = data; m_pc = m_pc + 1; end
               3: begin m_pc = puse ? m_btr[rg] : m_pc + 1; used = 1'b1; end
               4: begin m_awake = 1'b0; used = 1'b1; end
               default: m_pc = m_pc + 1;
            endcase
         end
      end else if (wk && !st) begin
         m_pc = m_btr[wrg]; m_awake = 1'b1; used = 1'b1;
      end
      if (used) m_pv = 1'b0;
      else if (nv) begin m_pv = 1'b1; m_pval = nval; end
   endtask

   initial begin
      #(20 * 5000);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; op_valid_i = 0; op_kind_i = 0; op_reg_i = 0; op_data_i = 0;
      op_pred_i = 0; pred_net_valid_i = 0; pred_net_value_i = 0;
      stall_i = 0; wake_i = 0; wake_reg_i = 0;
      m_pc = ENTRY; m_awake = 1'b1; m_pv = 1'b0; m_pval = 1'b0;
      for (int i = 0; i < 4; i++) m_btr[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state, R2 no valid op holds
      step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R3 prepare targets
      step("R3", 1, 1, 1, 32'h400, 0, 0, 0, 0, 0, 0);
      step("R3", 1, 1, 2, 32'h800, 0, 0, 0, 0, 0, 0);
      // R4 broadcast, R5 taken branch with same-cycle arrival (R6 bypass)
      step("R4", 1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R5", 1, 3, 1, 0, 0, 1, 1, 0, 0, 0);
      // R6 branch waits, then not taken
      step("R6", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
      step("R6", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
      step("R5", 1, 3, 2, 0, 0, 1, 0, 0, 0, 0);
      // R7 stall freezes prepare, broadcast; predicate arriving under stall is kept
      step("R7", 1, 1, 2, 32'hAAA, 0, 0, 0, 1, 0, 0);
      step("R7", 1, 2, 0, 0, 1, 1, 1, 1, 0, 0);
      step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R5", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
      // R3 branch on unwritten register
      step("R3", 1, 3, 3, 0, 0, 1, 1, 0, 0, 0);
      step("R2", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
      // R9 wake while awake is ignored
      step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      // R8 sleep waits, then sleeps
      step("R8", 1, 4, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R8", 1, 4, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R8", 1, 1, 1, 32'h999, 0, 0, 0, 0, 0, 0);
      step("R8", 1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R8", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
      // R10 predicate latched while asleep, R7 wake under stall has no effect
      step("R10", 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
      step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      // R10 branch after wake waits for fresh predicate
      step("R10", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
      step("R10", 1, 3, 2, 0, 0, 1, 1, 0, 0, 0);
      step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule